// File: doc/BRIEF.md
# GPIO Port Pad Control Register File

This block holds the configuration and data state of one 16-pin general-purpose I/O port. A simple 32-bit register bus reaches it: an address, a write strobe, write data and read data. Writes land on the clock edge, and reads return combinationally in the same cycle. Each pin has a 2-bit mode. The port also has an output data register, an output protect mask, a per-pin input-path disable, and a read-only view of the synchronised pad levels. Per-pin signals for output value, output enable and weak pull-up enable go out to the pad ring.

Besides the whole-port registers, every pin has an alias word of its own. Software can read or set one pin with a single word access, with no read-modify-write. Alias writes respect the protect mask in the same way as whole-port writes. Pad inputs pass through a two-flop synchroniser before any register sees them.

The block has no sequencing state. Its only state is the register bank and the synchroniser. The pad drive is a per-pin decode of mode and output bit with four named cases: input, push-pull, open-drain and quasi-bidirectional.

Top module: `gpio_port_regs`

Byte address map (defaults): 0x000 mode (pin i in bits 2i+1:2i), 0x004 output data (bits 15:0), 0x008 protect mask (bits 15:0), 0x00C input disable (bits 31:16, pin i at bit 16+i), 0x010 pin state (read-only, bits 15:0), 0x400 + 4*i alias word for pin i.

## Requirements
- R1: After reset all modes read 0 (input), the output data reads 0x0000FFFF, the protect mask reads 0, the input disable reads 0, and no pad is driven or pulled up.
- R2: In mode 1 (push-pull) a pin has pad_oe=1, pad_out equal to its output bit, and pad_pu=0.
- R3: In mode 2 (open-drain) a pin has pad_out=0, pad_oe asserted only while its output bit is 0, and pad_pu=0; no pin outside push-pull ever drives a 1.
- R4: In mode 3 (quasi-bidirectional) a pin drives low (pad_out=0, pad_oe=1) when its output bit is 0, and with a 1 it releases the pad and asserts pad_pu; pull-up is never asserted in any other mode.
- R5: In mode 0 (input) a pin has pad_oe=0 and pad_pu=0.
- R6: A write to the output data register changes only the bits whose protect mask bit is 0; masked bits keep their value.
- R7: Input disable bits sit at 31:16 of their register. A pin whose bit is set reads 0 in the pin state register and in its alias word.
- R8: The pin state register shows a pad level change on the second rising clock edge after it is applied, never on the first.
- R9: A read of pin i's alias word returns its pin state bit in bit 0, with bits 31:1 zero.
- R10: A write to pin i's alias word sets output bit i to write-data bit 0, unless mask bit i is set; other output bits are unchanged.
- R11: Reads of unmapped addresses return 0, and writes to the pin state register or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe, registered on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output value per pad |
| pad_oe | output | 16 | Output driver enable per pad |
| pad_pu | output | 16 | Weak pull-up enable per pad |

## Verification
Some rules are checked on every cycle by the assertions. Only push-pull pins may drive a 1, pull-up appears only on quasi-bidirectional pins, and input pins stay released. Masked output bits survive a whole-port write, and an unmasked alias write lands its bit. The synchronised level equals the pad level from two edges earlier, and disabled pins read back 0. The bench scenarios are the only evidence for the exact reset values, the readback of every register, the field positions, and the first-edge versus second-edge timing of the synchroniser. They alone also show that writes to read-only or unmapped addresses leave every register unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PINS       = 16;
    localparam int DATA_W     = 32;
    localparam int MODE_W     = 2;
    localparam int PIN_IDX_W  = $clog2(PINS);
    localparam int DIS_LSB    = 16;

    typedef enum logic [MODE_W-1:0] {
        PM_INPUT     = 2'd0,
        PM_PUSHPULL  = 2'd1,
        PM_OPENDRAIN = 2'd2,
        PM_QUASI     = 2'd3
    } pin_mode_e;

    localparam int OFS_MODE   = 'h000;
    localparam int OFS_DOUT   = 'h004;
    localparam int OFS_MASK   = 'h008;
    localparam int OFS_INDIS  = 'h00C;
    localparam int OFS_PSTATE = 'h010;

    localparam int ALIAS_STRIDE = 4;
    localparam int PORT_SPAN    = PINS * ALIAS_STRIDE;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_mode,
    input  logic                   wr_dout,
    input  logic                   wr_mask,
    input  logic                   wr_indis,
    input  logic                   wr_alias,
    input  logic [PIN_IDX_W-1:0]   alias_pin,
    input  logic [DATA_W-1:0]      wdata,
    output logic [MODE_W*PINS-1:0] mode_q,
    output logic [PINS-1:0]        dout_q,
    output logic [PINS-1:0]        mask_q,
    output logic [PINS-1:0]        indis_q
);

    logic [PINS-1:0] dout_next;

    always_comb begin
        dout_next = dout_q;
        if (wr_dout) begin
            dout_next = (dout_q & mask_q) | (wdata[PINS-1:0] & ~mask_q);
        end else if (wr_alias && !mask_q[alias_pin]) begin
            dout_next[alias_pin] = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dout_q  <= '1;
            mask_q  <= '0;
            indis_q <= '0;
        end else begin
            if (wr_mode)  mode_q  <= wdata[MODE_W*PINS-1:0];
            if (wr_mask)  mask_q  <= wdata[PINS-1:0];
            if (wr_indis) indis_q <= wdata[DIS_LSB +: PINS];
            dout_q <= dout_next;
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
(
    input  logic [MODE_W*PINS-1:0] mode_q,
    input  logic [PINS-1:0]        dout_q,
    output logic [PINS-1:0]        pad_out,
    output logic [PINS-1:0]        pad_oe,
    output logic [PINS-1:0]        pad_pu
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_mode_e pin_mode;
        assign pin_mode = pin_mode_e'(mode_q[MODE_W*i +: MODE_W]);

        always_comb begin
            unique case (pin_mode)
                PM_INPUT: begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = 1'b0;
                    pad_pu[i]  = 1'b0;
                end
                PM_PUSHPULL: begin
                    pad_out[i] = dout_q[i];
                    pad_oe[i]  = 1'b1;
                    pad_pu[i]  = 1'b0;
                end
                PM_OPENDRAIN: begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = ~dout_q[i];
                    pad_pu[i]  = 1'b0;
                end
                PM_QUASI: begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = ~dout_q[i];
                    pad_pu[i]  = dout_q[i];
                end
                default: begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = 1'b0;
                    pad_pu[i]  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ALIAS_BASE = 'h400,
    parameter int PORT_IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       pad_in,
    output logic [15:0]       pad_out,
    output logic [15:0]       pad_oe,
    output logic [15:0]       pad_pu
);

    localparam int ALIAS_LSB   = $clog2(PORT_SPAN);
    localparam int ALIAS_START = ALIAS_BASE + PORT_IDX * PORT_SPAN;
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_DOUT   = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_INDIS  = ADDR_W'(OFS_INDIS);
    localparam logic [ADDR_W-1:0] A_PSTATE = ADDR_W'(OFS_PSTATE);
    localparam logic [ADDR_W-1:0] A_ALIAS  = ADDR_W'(ALIAS_START);

    logic [MODE_W*PINS-1:0] mode_q;
    logic [PINS-1:0]        dout_q, mask_q, indis_q, sync_q, pin_state;
    logic                   alias_hit;
    logic [PIN_IDX_W-1:0]   alias_pin;

    assign alias_hit = (bus_addr[ADDR_W-1:ALIAS_LSB] == A_ALIAS[ADDR_W-1:ALIAS_LSB])
                    && (bus_addr[1:0] == 2'b00);
    assign alias_pin = bus_addr[2 +: PIN_IDX_W];

    gpio_in_sync #(.WIDTH(PINS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_q)
    );

    assign pin_state = sync_q & ~indis_q;

    gpio_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (bus_wr && bus_addr == A_MODE),
        .wr_dout   (bus_wr && bus_addr == A_DOUT),
        .wr_mask   (bus_wr && bus_addr == A_MASK),
        .wr_indis  (bus_wr && bus_addr == A_INDIS),
        .wr_alias  (bus_wr && alias_hit),
        .alias_pin (alias_pin),
        .wdata     (bus_wdata),
        .mode_q    (mode_q),
        .dout_q    (dout_q),
        .mask_q    (mask_q),
        .indis_q   (indis_q)
    );

    gpio_pad_drive u_drive (
        .mode_q  (mode_q),
        .dout_q  (dout_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    always_comb begin
        bus_rdata = '0;
        if (alias_hit) begin
            bus_rdata[0] = pin_state[alias_pin];
        end else if (bus_addr == A_MODE) begin
            bus_rdata = mode_q;
        end else if (bus_addr == A_DOUT) begin
            bus_rdata[PINS-1:0] = dout_q;
        end else if (bus_addr == A_MASK) begin
            bus_rdata[PINS-1:0] = mask_q;
        end else if (bus_addr == A_INDIS) begin
            bus_rdata[DIS_LSB +: PINS] = indis_q;
        end else if (bus_addr == A_PSTATE) begin
            bus_rdata[PINS-1:0] = pin_state;
        end
    end

    // ---------------- assertions ----------------
    logic [PINS-1:0] chk_pp, chk_quasi, chk_input;
    for (genvar i = 0; i < PINS; i++) begin : g_chk
        assign chk_pp[i]    = mode_q[MODE_W*i +: MODE_W] == 2'd1;
        assign chk_quasi[i] = mode_q[MODE_W*i +: MODE_W] == 2'd3;
        assign chk_input[i] = mode_q[MODE_W*i +: MODE_W] == 2'd0;
    end

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r3_no_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & pad_oe & ~chk_pp) == '0);

    a_r4_pullup_only_quasi: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~chk_quasi) == '0);

    a_r5_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pu) & chk_input) == '0);

    a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DOUT) |=> ((dout_q ^ $past(dout_q)) & $past(mask_q)) == '0);

    a_r10_alias_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && alias_hit && !mask_q[alias_pin]) |=> dout_q[$past(alias_pin)] == $past(bus_wdata[0]));

    a_r8_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> sync_q == $past(pad_in, 2));

    a_r7_disabled_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PSTATE) |-> (bus_rdata[PINS-1:0] & indis_q) == '0);

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

    localparam int A_MODE = 'h000, A_DOUT = 'h004, A_MASK = 'h008;
    localparam int A_INDIS = 'h00C, A_PSTATE = 'h010, A_ALIAS = 'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_mode;
    logic [15:0] m_dout, m_mask, m_dis;

    always #2 clk = ~clk;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_out(input logic [31:0] md, input logic [15:0] d);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r[i] = (md[2*i +: 2] == 2'd1) & d[i];
        return r;
    endfunction

    function automatic logic [15:0] exp_oe(input logic [31:0] md, input logic [15:0] d);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            case (md[2*i +: 2])
                2'd0: r[i] = 1'b0;
                2'd1: r[i] = 1'b1;
                default: r[i] = ~d[i];
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_pu(input logic [31:0] md, input logic [15:0] d);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r[i] = (md[2*i +: 2] == 2'd3) & d[i];
        return r;
    endfunction

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:0]; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:0]; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic model_dout(input logic [15:0] d);
        m_dout = (m_dout & m_mask) | (d & ~m_mask);
    endtask

    task automatic check_pads(input string tag);
        check({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, exp_out(m_mode, m_dout)});
        check({tag, " pad_oe"},  {16'h0, pad_oe},  {16'h0, exp_oe(m_mode, m_dout)});
        check({tag, " pad_pu"},  {16'h0, pad_pu},  {16'h0, exp_pu(m_mode, m_dout)});
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] r;
        bus_read(A_MODE, r);   check({tag, " mode"}, r, m_mode);
        bus_read(A_DOUT, r);   check({tag, " dout"}, r, {16'h0, m_dout});
        bus_read(A_MASK, r);   check({tag, " mask"}, r, {16'h0, m_mask});
        bus_read(A_INDIS, r);  check({tag, " indis"}, r, {m_dis, 16'h0});
        bus_read(A_PSTATE, r); check({tag, " pstate"}, r, {16'h0, pad_in & ~m_dis});
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        m_mode = '0; m_dout = 16'hFFFF; m_mask = '0; m_dis = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check_regs("R1");
        check_pads("R1");

        // R2 push-pull with a pattern
        bus_write(A_MODE, 32'h5555_5555); m_mode = 32'h5555_5555;
        bus_write(A_DOUT, 32'h0000_A5C3); model_dout(16'hA5C3);
        check_pads("R2");
        // R3 open-drain
        bus_write(A_MODE, 32'hAAAA_AAAA); m_mode = 32'hAAAA_AAAA;
        check_pads("R3");
        // R4 quasi-bidirectional
        bus_write(A_MODE, 32'hFFFF_FFFF); m_mode = 32'hFFFF_FFFF;
        check_pads("R4");
        // R5 input, mixed pins
        bus_write(A_MODE, 32'h1B1B_001B); m_mode = 32'h1B1B_001B;
        check_pads("R5");

        // R6 mask protects
        bus_write(A_MASK, 32'h0000_FF00); m_mask = 16'hFF00;
        bus_write(A_DOUT, 32'h0000_0000); model_dout(16'h0000);
        bus_read(A_DOUT, r); check("R6 masked write", r, {16'h0, m_dout});
        check("R6 upper kept", {16'h0, r[15:8], 8'h0}, 32'h0000_A500);

        // R10 alias write obeys mask
        bus_write(A_ALIAS + 4*15, 32'h0000_0000);
        bus_write(A_ALIAS + 4*0, 32'hFFFF_FFFF); m_dout[0] = 1'b1;
        bus_read(A_DOUT, r); check("R10 alias write", r, {16'h0, m_dout});

        // R8 synchroniser timing
        @(negedge clk); pad_in = 16'h0000; bus_addr = A_PSTATE[11:0];
        repeat (3) @(negedge clk);
        pad_in = 16'hBEEF;
        @(negedge clk); #1 check("R8 first edge", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R8 second edge", bus_rdata, 32'h0000_BEEF);

        // R7 disable
        bus_write(A_INDIS, 32'h00F0_FFFF); m_dis = 16'h00F0;
        bus_read(A_PSTATE, r); check("R7 disabled pins", r, {16'h0, 16'hBEEF & ~16'h00F0});
        bus_read(A_ALIAS + 4*5, r); check("R7 alias disabled", r, 32'h0);
        // R9 alias read
        bus_read(A_ALIAS + 4*3, r); check("R9 alias read", r, 32'h1);
        bus_read(A_ALIAS + 4*4, r); check("R9 alias read zero", r, 32'h0);

        // R11 read-only / unmapped
        bus_write(A_PSTATE, 32'hFFFF_FFFF);
        bus_write('h020, 32'h0);
        bus_write('h3FC, 32'h0);
        check_regs("R11 after ignored writes");
        bus_read('h020, r); check("R11 unmapped read", r, 32'h0);
        bus_read('h440, r); check("R11 past alias read", r, 32'h0);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 6);
            logic [31:0] d = $urandom();
            int p = $urandom_range(0, 15);
            case (op)
                0: begin bus_write(A_MODE, d); m_mode = d; end
                1: begin bus_write(A_DOUT, d); model_dout(d[15:0]); end
                2: begin bus_write(A_MASK, d & $urandom()); m_mask = d[15:0] & r[15:0]; end
                3: begin bus_write(A_INDIS, d); m_dis = d[31:16]; end
                4: begin
                    bus_write(A_ALIAS + 4*p, d);
                    if (!m_mask[p]) m_dout[p] = d[0];
                end
                5: begin
                    @(negedge clk); pad_in = d[15:0];
                    repeat (3) @(negedge clk);
                end
                default: begin
                    bus_read(A_ALIAS + 4*p, r);
                    check("R9 random alias", r, {31'h0, pad_in[p] & ~m_dis[p]});
                end
            endcase
            if (op == 2) begin
                bus_read(A_MASK, r); m_mask = r[15:0];
                check("R6 mask readback", r, {16'h0, m_mask});
            end
            if (it % 10 == 0) begin
                check_regs("R6 random");
                check_pads("R3 random");
            end
        end
        check_regs("R10 final");
        check_pads("R2 final");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule